// File: doc/BRIEF.md
# LCD Command Decoder and Display-RAM Address Controller

This block sits between an already-decoded host bus and the frame memory of a dot-matrix LCD controller. Every host transaction arrives as one byte with two qualifiers: a select bit that says whether the byte is an instruction or display data, and a direction bit that says whether the host writes or reads. Instructions load the page, column and display start-line registers, set the display mode flags, and control a read-modify-write mode. Data transactions become strobes into the display RAM at the current page and column, and the column then advances by one.

Reads come back one cycle after the transaction is accepted, with `rdata_valid` high for that one cycle. A status read returns a byte built from the mode flags. A display data read works like a pipeline: it returns the RAM byte fetched by the previous data read and starts a fresh fetch at the current address. After an address change, the host therefore issues one dummy read. The RAM answers one cycle after `ram_re`.

The host side is a valid/ready stream. A transaction is accepted on a rising clock edge when `in_valid` and `in_ready` are both high. `in_ready` drops for exactly one cycle after each accepted display data read, while the fetch is in flight. The host must then hold its transaction stable until ready returns. The read data output has no back-pressure. The host must take `rdata` in the cycle `rdata_valid` is high.

Top module: `lcd_cmd_ctrl`

## Requirements
- R1: After reset all mode flags are 0 (display off), page, column and start line are 0, read-modify-write is inactive, `rdata_valid` is 0 and `in_ready` is 1.
- R2: An accepted data write (select 1, direction 0) asserts `ram_we` in the accepting cycle with the current page, column and byte. The column is one higher afterwards.
- R3: The column never exceeds 79. Accesses at column 79 go to column 79 and leave it there; it never moves into another page.
- R4: Instruction bytes 0x00–0x4F load the column with their low 7 bits. Bytes 0x50–0x7F change nothing.
- R5: Instruction 0b101110pp loads the 2-bit page pp. Instruction 0b110lllll loads the 5-bit start line.
- R6: Instruction pairs 0xAE/0xAF, 0xA0/0xA1, 0xA4/0xA5 and 0xA8/0xA9 load bit 0 into display-on, column reversal, static drive and 1/32 duty respectively.
- R7: A status read (select 0, direction 1) gives `rdata_valid` one cycle later with byte {0, column reversal, display-off, 0, 0000} (bit 7 down to bit 0).
- R8: A data read asserts `ram_re` at the current page and column in the accepting cycle. One cycle later it returns the byte fetched by the previous data read (0x00 before any fetch). It advances the column when read-modify-write is inactive.
- R9: 0xE0 enters read-modify-write and records the column; while active, reads leave the column in place and writes advance it. 0xEE leaves the mode and restores the recorded column; 0xE0 while active and 0xEE while inactive change nothing.
- R10: Instruction 0xE2 clears page, column and start line. All mode flags and the read-modify-write state are left unchanged.
- R11: Any other instruction byte (for example 0xA2, 0xBC, 0xE1, 0xFF) changes no register and no output.
- R12: `in_ready` is 0 in the cycle after an accepted data read. A transaction offered then is not accepted and causes no RAM strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Host transaction offered |
| in_ready | output | 1 | Block can accept a transaction |
| in_sel | input | 1 | 1 = display data, 0 = instruction/status |
| in_rnw | input | 1 | 1 = read, 0 = write |
| in_byte | input | 8 | Instruction or write data byte |
| rdata_valid | output | 1 | Read result present (one cycle) |
| rdata | output | 8 | Status or display read byte |
| ram_we | output | 1 | Display RAM write strobe |
| ram_re | output | 1 | Display RAM read strobe |
| ram_page | output | 2 | RAM page address |
| ram_col | output | 7 | RAM column address |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, valid the cycle after `ram_re` |
| disp_on | output | 1 | Display enable flag |
| col_rev | output | 1 | Column-to-segment order reversed |
| static_drv | output | 1 | Static all-on drive flag |
| duty32 | output | 1 | 1/32 duty selected (0 = 1/16) |
| start_line | output | 5 | Line shown on the first common row |
| rmw_active | output | 1 | Read-modify-write mode active |

## Verification
The hardest situation to reach is the interaction between the delayed-read buffer and the column rules. This covers the byte returned by a read that follows a column change inside read-modify-write, and reads at the saturated end of a page. The stimulus first writes a computed pattern over every cell, including a repeated write at column 79. It then reads every page back in one pass and predicts each result from the previous fetch. A read-modify-write sequence then changes cells in place and reads them back. A sweep of all 256 instruction bytes, compared after each byte against an arithmetic model, reaches the ignored, clamped and restoring cases. The sweep includes entering read-modify-write, clearing addresses inside it, and leaving it.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  typedef enum logic [3:0] {
    OP_NONE, OP_COL, OP_LINE, OP_PAGE, OP_DISP, OP_ADC,
    OP_STATIC, OP_DUTY, OP_RMW_ON, OP_RMW_OFF, OP_HOME
  } op_e;

  // flag vector order: display on, column reversal, static drive, 1/32 duty
  localparam int FLAG_N = 4;

  function automatic op_e flag_op(input int idx);
    case (idx)
      0:       return OP_DISP;
      1:       return OP_ADC;
      2:       return OP_STATIC;
      default: return OP_DUTY;
    endcase
  endfunction
endpackage

// File: rtl/lcd_op_decode.sv
module lcd_op_decode
  import lcd_pkg::*;
(
  input  logic [7:0] code,
  output op_e        op
);
  always_comb begin
    op = OP_NONE;
    if (!code[7])                     op = OP_COL;
    else if (code[7:5] == 3'b110)     op = OP_LINE;
    else if (code[7:2] == 6'b101110)  op = OP_PAGE;
    else begin
      case (code)
        8'hAE, 8'hAF: op = OP_DISP;
        8'hA0, 8'hA1: op = OP_ADC;
        8'hA4, 8'hA5: op = OP_STATIC;
        8'hA8, 8'hA9: op = OP_DUTY;
        8'hE0:        op = OP_RMW_ON;
        8'hEE:        op = OP_RMW_OFF;
        8'hE2:        op = OP_HOME;
        default:      op = OP_NONE;
      endcase
    end
  end
endmodule

// File: rtl/lcd_mode_regs.sv
module lcd_mode_regs
  import lcd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_en,
  input  op_e               op,
  input  logic              val,
  output logic [FLAG_N-1:0] flags
);
  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        q <= 1'b0;
      else if (op_en && op == flag_op(i)) q <= val;
    end
    assign flags[i] = q;
  end
endmodule

// File: rtl/lcd_addr_ctrl.sv
module lcd_addr_ctrl
  import lcd_pkg::*;
#(
  parameter int COLS   = 80,
  parameter int PAGE_W = 2,
  parameter int LINE_W = 5,
  localparam int COL_W = $clog2(COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_en,
  input  op_e               op,
  input  logic [7:0]        arg,
  input  logic              data_wr,
  input  logic              data_rd,
  output logic [PAGE_W-1:0] page,
  output logic [COL_W-1:0]  col,
  output logic [LINE_W-1:0] line,
  output logic              rmw
);
  localparam logic [COL_W-1:0] LAST_COL = COL_W'(COLS - 1);

  logic [COL_W-1:0] col_saved;
  logic             col_arg_ok;
  logic             step;

  assign col_arg_ok = ({1'b0, arg[6:0]} < 8'(COLS));
  assign step       = data_wr || (data_rd && !rmw);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page      <= '0;
      col       <= '0;
      line      <= '0;
      rmw       <= 1'b0;
      col_saved <= '0;
    end else if (op_en) begin
      case (op)
        OP_COL:     if (col_arg_ok) col <= COL_W'(arg[6:0]);
        OP_LINE:    line <= arg[LINE_W-1:0];
        OP_PAGE:    page <= arg[PAGE_W-1:0];
        OP_RMW_ON:  if (!rmw) begin
                      rmw       <= 1'b1;
                      col_saved <= col;
                    end
        OP_RMW_OFF: if (rmw) begin
                      rmw <= 1'b0;
                      col <= col_saved;
                    end
        OP_HOME:    begin
                      page <= '0;
                      col  <= '0;
                      line <= '0;
                    end
        default:    ;
      endcase
    end else if (step && col != LAST_COL) begin
      col <= col + 1'b1;
    end
  end
endmodule

// File: rtl/lcd_rd_path.sv
module lcd_rd_path (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       stat_rd,
  input  logic       data_rd,
  input  logic [7:0] status,
  input  logic [7:0] ram_rdata,
  output logic       fetch_pend,
  output logic       rvalid,
  output logic [7:0] rbyte
);
  logic [7:0] held;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fetch_pend <= 1'b0;
      rvalid     <= 1'b0;
      rbyte      <= '0;
      held       <= '0;
    end else begin
      fetch_pend <= data_rd;
      rvalid     <= stat_rd || data_rd;
      if (stat_rd)      rbyte <= status;
      else if (data_rd) rbyte <= held;
      if (fetch_pend)   held  <= ram_rdata;
    end
  end
endmodule

// File: rtl/lcd_cmd_ctrl.sv
module lcd_cmd_ctrl
  import lcd_pkg::*;
#(
  parameter int COLS  = 80,
  parameter int PAGES = 4,
  parameter int LINES = 32,
  localparam int COL_W  = $clog2(COLS),
  localparam int PAGE_W = $clog2(PAGES),
  localparam int LINE_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_sel,
  input  logic              in_rnw,
  input  logic [7:0]        in_byte,
  output logic              rdata_valid,
  output logic [7:0]        rdata,
  output logic              ram_we,
  output logic              ram_re,
  output logic [PAGE_W-1:0] ram_page,
  output logic [COL_W-1:0]  ram_col,
  output logic [7:0]        ram_wdata,
  input  logic [7:0]        ram_rdata,
  output logic              disp_on,
  output logic              col_rev,
  output logic              static_drv,
  output logic              duty32,
  output logic [LINE_W-1:0] start_line,
  output logic              rmw_active
);
  op_e               op;
  logic              accept, op_en, stat_rd, fetch_pend;
  logic [FLAG_N-1:0] flags;
  logic [7:0]        status;

  assign in_ready = !fetch_pend;
  assign accept   = in_valid && in_ready;
  assign op_en    = accept && !in_sel && !in_rnw;
  assign stat_rd  = accept && !in_sel && in_rnw;
  assign ram_we   = accept && in_sel && !in_rnw;
  assign ram_re   = accept && in_sel && in_rnw;
  assign ram_wdata = in_byte;

  assign disp_on    = flags[0];
  assign col_rev    = flags[1];
  assign static_drv = flags[2];
  assign duty32     = flags[3];
  // busy and resetting never show: every operation completes in one cycle
  assign status = {1'b0, col_rev, !disp_on, 1'b0, 4'b0000};

  lcd_op_decode u_dec (.code(in_byte), .op(op));

  lcd_mode_regs u_modes (
    .clk(clk), .rst_n(rst_n), .op_en(op_en), .op(op),
    .val(in_byte[0]), .flags(flags)
  );

  lcd_addr_ctrl #(.COLS(COLS), .PAGE_W(PAGE_W), .LINE_W(LINE_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .op_en(op_en), .op(op), .arg(in_byte),
    .data_wr(ram_we), .data_rd(ram_re),
    .page(ram_page), .col(ram_col), .line(start_line), .rmw(rmw_active)
  );

  lcd_rd_path u_rd (
    .clk(clk), .rst_n(rst_n), .stat_rd(stat_rd), .data_rd(ram_re),
    .status(status), .ram_rdata(ram_rdata), .fetch_pend(fetch_pend),
    .rvalid(rdata_valid), .rbyte(rdata)
  );
endmodule

// File: rtl/lcd_cmd_ctrl_chk.sv
module lcd_cmd_ctrl_chk #(
  parameter int COLS = 80
) (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic       in_ready,
  input logic       in_sel,
  input logic       in_rnw,
  input logic [7:0] in_byte,
  input logic       rdata_valid,
  input logic       ram_we,
  input logic       ram_re,
  input logic [1:0] ram_page,
  input logic [6:0] ram_col,
  input logic [4:0] start_line,
  input logic       disp_on,
  input logic       col_rev,
  input logic       rmw_active
);
  logic acc;
  assign acc = in_valid && in_ready;

  AST_COL_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    32'(ram_col) <= COLS - 1); // R3

  AST_WR_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && 32'(ram_col) != COLS - 1) |=> ram_col == $past(ram_col) + 7'd1); // R2

  AST_READ_ANSWER: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_rnw) |=> rdata_valid); // R7

  AST_STALL_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && in_rnw && in_sel) |=> !in_ready); // R8

  AST_NO_STROBE_STALLED: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> !ram_we && !ram_re); // R12

  AST_RMW_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_re && rmw_active) |=> ram_col == $past(ram_col)); // R9

  AST_HOME_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_sel && !in_rnw && in_byte == 8'hE2)
      |=> ram_col == 7'd0 && ram_page == 2'd0 && start_line == 5'd0); // R10

  AST_HOME_KEEPS_MODES: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !in_sel && !in_rnw && in_byte == 8'hE2)
      |=> $stable(disp_on) && $stable(col_rev) && $stable(rmw_active)); // R10
endmodule

bind lcd_cmd_ctrl lcd_cmd_ctrl_chk #(.COLS(COLS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_sel(in_sel), .in_rnw(in_rnw), .in_byte(in_byte),
  .rdata_valid(rdata_valid), .ram_we(ram_we), .ram_re(ram_re),
  .ram_page(ram_page), .ram_col(ram_col), .start_line(start_line),
  .disp_on(disp_on), .col_rev(col_rev), .rmw_active(rmw_active)
);

// File: tb/lcd_cmd_ctrl_test.sv
`timescale 1ns/1ps
module lcd_cmd_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       in_valid = 1'b0, in_sel = 1'b0, in_rnw = 1'b0;
  logic [7:0] in_byte = 8'h00;
  logic       in_ready, rdata_valid, ram_we, ram_re;
  logic [7:0] rdata, ram_wdata, ram_rdata;
  logic [1:0] ram_page;
  logic [6:0] ram_col;
  logic       disp_on, col_rev, static_drv, duty32, rmw_active;
  logic [4:0] start_line;

  always #4 clk = ~clk;

  lcd_cmd_ctrl uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sel(in_sel), .in_rnw(in_rnw), .in_byte(in_byte),
    .rdata_valid(rdata_valid), .rdata(rdata), .ram_we(ram_we), .ram_re(ram_re),
    .ram_page(ram_page), .ram_col(ram_col), .ram_wdata(ram_wdata),
    .ram_rdata(ram_rdata), .disp_on(disp_on), .col_rev(col_rev),
    .static_drv(static_drv), .duty32(duty32), .start_line(start_line),
    .rmw_active(rmw_active)
  );

  // display RAM model: registered read
  logic [7:0] mem [320];
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 320; i++) mem[i] <= 8'h00;
      ram_rdata <= 8'h00;
    end else begin
      if (ram_we) mem[int'(ram_page) * 80 + int'(ram_col)] <= ram_wdata;
      if (ram_re) ram_rdata <= mem[int'(ram_page) * 80 + int'(ram_col)];
    end
  end

  int  total = 0, failed = 0;
  bit  done = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      failed++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // values seen in the accepting cycle and one cycle later
  logic       s_we, s_re;
  logic [1:0] s_page;
  logic [6:0] s_col;
  logic [7:0] s_wdata, r_byte;
  logic       r_valid;

  task automatic xfer(input logic sel, input logic rnw, input logic [7:0] b);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_sel = sel; in_rnw = rnw; in_byte = b;
    #1;
    s_we = ram_we; s_re = ram_re; s_page = ram_page; s_col = ram_col; s_wdata = ram_wdata;
    @(negedge clk);
    in_valid = 1'b0;
    r_valid = rdata_valid; r_byte = rdata;
  endtask

  // arithmetic model of the register state
  logic m_disp, m_rev, m_stat, m_duty, m_rmw;
  logic [4:0] m_line;
  logic [1:0] m_page;
  logic [6:0] m_col, m_save;

  task automatic model_op(input logic [7:0] b);
    if (b < 8'h80) begin
      if (b < 8'd80) m_col = b[6:0];
    end else if (b[7:5] == 3'b110) m_line = b[4:0];
    else if (b[7:2] == 6'b101110) m_page = b[1:0];
    else if (b[7:1] == 7'h57) m_disp = b[0];
    else if (b[7:1] == 7'h50) m_rev  = b[0];
    else if (b[7:1] == 7'h52) m_stat = b[0];
    else if (b[7:1] == 7'h54) m_duty = b[0];
    else if (b == 8'hE0) begin if (!m_rmw) begin m_rmw = 1'b1; m_save = m_col; end end
    else if (b == 8'hEE) begin if (m_rmw) begin m_rmw = 1'b0; m_col = m_save; end end
    else if (b == 8'hE2) begin m_col = '0; m_page = '0; m_line = '0; end
  endtask

  function automatic string tag_of(input logic [7:0] b);
    if (b < 8'h50) return "R4";
    if (b < 8'h80) return "R4 ignored";
    if (b[7:5] == 3'b110 || b[7:2] == 6'b101110) return "R5";
    if (b == 8'hAE || b == 8'hAF || b == 8'hA0 || b == 8'hA1 ||
        b == 8'hA4 || b == 8'hA5 || b == 8'hA8 || b == 8'hA9) return "R6";
    if (b == 8'hE0 || b == 8'hEE) return "R9";
    if (b == 8'hE2) return "R10";
    return "R11";
  endfunction

  function automatic logic [7:0] pat(input int p, input int c);
    return 8'((p * 80 + c) * 37 + 8'h3C);
  endfunction

  logic [7:0] exp_mem [320];
  logic [7:0] prev;

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check("R1 flags", {disp_on, col_rev, static_drv, duty32, rmw_active}, 0);
    check("R1 addr", {start_line, ram_page, ram_col}, 0);
    check("R1 handshake", {in_ready, rdata_valid}, 2'b10);
    xfer(1'b0, 1'b1, 8'h00);
    check("R7 status after reset", {r_valid, r_byte}, {1'b1, 8'h20});

    // exhaustive instruction sweep
    m_disp = 0; m_rev = 0; m_stat = 0; m_duty = 0; m_rmw = 0;
    m_line = 0; m_page = 0; m_col = 0; m_save = 0;
    for (int b = 0; b < 256; b++) begin
      xfer(1'b0, 1'b0, 8'(b));
      model_op(8'(b));
      check(tag_of(8'(b)),
            {disp_on, col_rev, static_drv, duty32, rmw_active, start_line, ram_page, ram_col},
            {m_disp, m_rev, m_stat, m_duty, m_rmw, m_line, m_page, m_col});
      if (b[3:0] == 4'hF || b == 8'hA1 || b == 8'hAE || b == 8'hAF) begin
        xfer(1'b0, 1'b1, 8'h00);
        check("R7 status", {r_valid, r_byte}, {1'b1, 1'b0, m_rev, ~m_disp, 5'b0});
      end
    end

    // write every cell, then a repeated write at the last column
    for (int p = 0; p < 4; p++) begin
      xfer(1'b0, 1'b0, 8'hB8 | 8'(p));
      xfer(1'b0, 1'b0, 8'h00);
      for (int c = 0; c < 80; c++) begin
        xfer(1'b1, 1'b0, pat(p, c));
        check("R2 write", {s_we, s_page, s_col, s_wdata}, {1'b1, 2'(p), 7'(c), pat(p, c)});
        exp_mem[p * 80 + c] = pat(p, c);
      end
      check("R3 saturate", ram_col, 79);
      xfer(1'b1, 1'b0, ~pat(p, 79));
      check("R3 write at end", {s_we, s_col, ram_col, ram_page}, {1'b1, 7'd79, 7'd79, 2'(p)});
      exp_mem[p * 80 + 79] = ~pat(p, 79);
    end

    // read everything back through the delayed read buffer
    prev = 8'h00;
    for (int p = 0; p < 4; p++) begin
      xfer(1'b0, 1'b0, 8'hB8 | 8'(p));
      xfer(1'b0, 1'b0, 8'h00);
      for (int c = 0; c < 80; c++) begin
        xfer(1'b1, 1'b1, 8'h00);
        check("R8 read", {s_re, s_page, s_col, r_valid, r_byte},
              {1'b1, 2'(p), 7'(c), 1'b1, prev});
        prev = exp_mem[p * 80 + c];
      end
      check("R3 read end", ram_col, 79);
    end

    // back-pressure after a data read
    xfer(1'b1, 1'b1, 8'h00);
    prev = exp_mem[3 * 80 + 79];
    in_valid = 1'b1; in_sel = 1'b1; in_rnw = 1'b0; in_byte = 8'h99;
    #1;
    check("R12 stalled", {in_ready, ram_we}, 2'b00);
    @(negedge clk);
    in_valid = 1'b0;
    check("R12 no advance", {ram_col, ram_page}, {7'd79, 2'd3});

    // read-modify-write
    xfer(1'b0, 1'b0, 8'hB9);
    xfer(1'b0, 1'b0, 8'd10);
    xfer(1'b0, 1'b0, 8'hE0);
    check("R9 enter", rmw_active, 1);
    xfer(1'b1, 1'b1, 8'h00);
    check("R9 read holds", {s_col, ram_col, r_byte}, {7'd10, 7'd10, prev});
    prev = exp_mem[80 + 10];
    xfer(1'b1, 1'b1, 8'h00);
    check("R9 read in mode", {ram_col, r_byte}, {7'd10, prev});
    xfer(1'b1, 1'b0, 8'hAA);
    check("R9 write advances", {s_col, ram_col}, {7'd10, 7'd11});
    xfer(1'b1, 1'b0, 8'hBB);
    check("R9 write advances 2", ram_col, 12);
    xfer(1'b0, 1'b0, 8'hE2);
    check("R10 home in mode", {rmw_active, ram_col, ram_page, disp_on}, {1'b1, 7'd0, 2'd0, 1'b1});
    xfer(1'b0, 1'b0, 8'hB9);
    xfer(1'b0, 1'b0, 8'hEE);
    check("R9 exit restores", {rmw_active, ram_col}, {1'b0, 7'd10});
    xfer(1'b1, 1'b1, 8'h00);
    xfer(1'b1, 1'b1, 8'h00);
    check("R8 readback after rmw", {r_byte, ram_col}, {8'hAA, 7'd12});
    xfer(1'b1, 1'b1, 8'h00);
    check("R8 readback 2", r_byte, 8'hBB);

    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; failed++;
      $display("FAIL watchdog actual=hung expected=complete");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule